// File: doc/BRIEF.md
# Multi-Format Synchronous Serial Master

This block is a full-duplex serial master. It always drives the bit clock (`sclk`), the frame line (`sfrm`) and the transmit data line (`txd`), and it samples `rxd` on every rising bit-clock edge. It takes words from an 8-entry transmit FIFO. Each received word goes into an 8-entry receive FIFO. Both FIFOs raise a service request when they need attention. The bit clock comes from the core clock through an 8-bit divider. Each bit lasts `2*(div+1)` core cycles, so a 3.6864 MHz reference covers 7.2 kHz up to 1.8432 MHz.

Three framing conventions share one shift engine:
- **SPI-style:** the frame line is held low for the whole word.
- **TI-style:** the frame line gives a one-bit high pulse just before the MSB.
- **Microwire-style:** an 8-bit command goes out first, and a reply word of the programmed length comes back.

Word length runs from 4 to 16 bits. Data goes out MSB first. Received words are right-justified.

The engine is a state machine with five states:
- `ST_IDLE` waits for `en` and for data in the transmit FIFO.
- `ST_SYNC` is the TI pulse bit.
- `ST_CMD` sends the Microwire command.
- `ST_DATA` shifts the word.
- `ST_DONE` is a one-bit inactive gap that ends in the push to the receive FIFO.

The transitions are:
- **Start:** `ST_IDLE` goes to `ST_SYNC` (TI), `ST_CMD` (Microwire) or `ST_DATA` (otherwise).
- **Shift:** `ST_SYNC` goes to `ST_DATA`, and `ST_CMD` goes to `ST_DATA`.
- **End:** `ST_DATA` goes to `ST_DONE`.
- **Retire:** `ST_DONE` goes to `ST_IDLE`.

Top module: `ssm_top`

## Requirements
- R1: Every bit lasts 2*(div+1) clk cycles. sclk is low for the first half of the bit and high for the second half, so rising sclk edges inside a word are 2*(div+1) cycles apart. sclk rests low whenever no bit is in progress.
- R2: `wlen` holds the word length minus one. Codes 0 to 2 are treated as a 4-bit word.
- R3: Data leaves MSB first on txd, which changes only while sclk is low. rxd is captured on each rising sclk edge.
- R4: SPI-style (fmt=0, and also the spare code fmt=3): sfrm is low for exactly the data bits of the word and high otherwise.
- R5: TI-style (fmt=1): sfrm is high for exactly one bit period, the one just before the MSB, and low otherwise.
- R6: Microwire-style (fmt=2): the frame is 8 + L bits long. The first 8 bits send bits [7:0] of the transmit word MSB first. During the next L bits txd is low and rxd is captured. sfrm is low for the whole frame.
- R7: A received word of L bits is stored in bits [L-1:0] of the receive FIFO entry, with the upper bits zero.
- R8: Each FIFO holds 8 words. A write to a full transmit FIFO is ignored. tx_req is high while the transmit FIFO holds 4 or fewer words. rx_req is high while the receive FIFO holds 4 or more words.
- R9: A frame starts only while en is high and the transmit FIFO is not empty. Frames keep following each other while words remain.
- R10: busy is high while a frame is in progress or the transmit FIFO is not empty.
- R11: rx_ovr is set when a received word arrives while the receive FIFO is full. That word is dropped. rx_ovr stays set until en goes low.
- R12: After reset:
  - sclk, txd, busy and rx_ovr are low;
  - both FIFOs are empty, so rx_empty and tx_req are high;
  - sfrm rests at its idle level for the selected format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core/reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Allows frames to start; low clears rx_ovr |
| fmt | input | 2 | Frame format: 0 SPI, 1 TI, 2 Microwire, 3 as SPI |
| wlen | input | 4 | Word length minus one |
| div | input | 8 | Bit-clock divider N: bit = 2*(N+1) clk |
| tx_wr | input | 1 | Write tx_data into transmit FIFO |
| tx_data | input | 16 | Transmit word |
| tx_full | output | 1 | Transmit FIFO full |
| tx_req | output | 1 | Transmit service request |
| rx_rd | input | 1 | Pop the receive FIFO |
| rx_data | output | 16 | Head of receive FIFO |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_req | output | 1 | Receive service request |
| rx_ovr | output | 1 | Sticky receive overrun |
| busy | output | 1 | Frame in progress or transmit data pending |
| sclk | output | 1 | Serial bit clock |
| sfrm | output | 1 | Frame signal |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |

## Verification
The overrun case is the hardest to reach from the ports. The receive FIFO must already be full when a ninth word completes, and the transmit FIFO can hold only eight words, so one burst cannot do it. The bench runs eight loopback frames without reading, lets the block go idle, then writes one more word and checks both that rx_ovr is set and that the head of the FIFO is still the first word. Microwire replies cannot be looped back because txd is low while the reply is captured. For these, the bench loads a slave shift register that advances on falling sclk edges and puts eight dummy bits ahead of the reply.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
    typedef enum logic [1:0] {
        FMT_SPI = 2'd0,
        FMT_TI  = 2'd1,
        FMT_MW  = 2'd2,
        FMT_ALT = 2'd3
    } frame_fmt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_CMD,
        ST_DATA,
        ST_DONE
    } eng_state_t;

    localparam int MIN_LEN = 4;
endpackage

// File: rtl/ssm_fifo.sv
module ssm_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= wr_ptr + 1'b1;
            end
            if (do_pop) rd_ptr <= rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/ssm_clkdiv.sv
module ssm_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ssm_engine.sv
module ssm_engine
    import ssm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CMD_W  = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        fmt,
    input  logic [IDX_W-1:0]  wlen,
    input  logic              tick,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              rxd,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_word,
    output logic              run,
    output logic              sclk,
    output logic              sfrm,
    output logic              txd
);
    localparam logic [IDX_W-1:0] LEN_FLOOR = IDX_W'(MIN_LEN - 1);
    localparam logic [IDX_W-1:0] CMD_TOP   = IDX_W'(CMD_W - 1);

    eng_state_t        state;
    frame_fmt_t        fmt_q;
    logic              phase;
    logic [IDX_W-1:0]  bit_idx, len_q, len_eff;
    logic [DATA_W-1:0] word, rx_sh;
    logic              bit_end;

    assign len_eff = (wlen < LEN_FLOOR) ? LEN_FLOOR : wlen;
    assign bit_end = tick && phase;
    assign tx_pop  = (state == ST_IDLE) && en && !tx_empty;
    assign rx_push = (state == ST_DONE) && bit_end;
    assign rx_word = rx_sh;
    assign run     = (state != ST_IDLE);

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            fmt_q   <= FMT_SPI;
            phase   <= 1'b0;
            bit_idx <= '0;
            len_q   <= LEN_FLOOR;
            word    <= '0;
            rx_sh   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    phase <= 1'b0;
                    if (tx_pop) begin
                        word  <= tx_word;
                        fmt_q <= frame_fmt_t'(fmt);
                        len_q <= len_eff;
                        rx_sh <= '0;
                        unique case (frame_fmt_t'(fmt))
                            FMT_TI: begin
                                state   <= ST_SYNC;
                                bit_idx <= len_eff;
                            end
                            FMT_MW: begin
                                state   <= ST_CMD;
                                bit_idx <= CMD_TOP;
                            end
                            FMT_SPI, FMT_ALT: begin
                                state   <= ST_DATA;
                                bit_idx <= len_eff;
                            end
                        endcase
                    end
                end
                ST_SYNC, ST_CMD, ST_DATA, ST_DONE: begin
                    if (tick) begin
                        phase <= !phase;
                        if (!phase && state == ST_DATA)
                            rx_sh <= {rx_sh[DATA_W-2:0], rxd};
                    end
                    if (bit_end) begin
                        unique case (state)
                            ST_SYNC: state <= ST_DATA;
                            ST_CMD: begin
                                if (bit_idx == '0) begin
                                    state   <= ST_DATA;
                                    bit_idx <= len_q;
                                end else begin
                                    bit_idx <= bit_idx - 1'b1;
                                end
                            end
                            ST_DATA: begin
                                if (bit_idx == '0) state <= ST_DONE;
                                else               bit_idx <= bit_idx - 1'b1;
                            end
                            ST_DONE: state <= ST_IDLE;
                            default: state <= ST_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end

    // output process
    always_comb begin
        sclk = 1'b0;
        sfrm = 1'b0;
        txd  = 1'b0;
        unique case (state)
            ST_IDLE: sfrm = (frame_fmt_t'(fmt) != FMT_TI);
            ST_SYNC: begin
                sclk = phase;
                sfrm = 1'b1;
            end
            ST_CMD: begin
                sclk = phase;
                txd  = word[bit_idx];
            end
            ST_DATA: begin
                sclk = phase;
                txd  = (fmt_q == FMT_MW) ? 1'b0 : word[bit_idx];
            end
            ST_DONE: sfrm = (fmt_q != FMT_TI);
        endcase
    end
endmodule

// File: rtl/ssm_top.sv
module ssm_top #(
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 8,
    parameter int DIV_W      = 8,
    parameter int CMD_W      = 8,
    localparam int IDX_W     = $clog2(DATA_W),
    localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        fmt,
    input  logic [IDX_W-1:0]  wlen,
    input  logic [DIV_W-1:0]  div,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_full,
    output logic              tx_req,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_empty,
    output logic              rx_req,
    output logic              rx_ovr,
    output logic              busy,
    output logic              sclk,
    output logic              sfrm,
    output logic              txd,
    input  logic              rxd
);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(FIFO_DEPTH / 2);

    logic              div_tick, eng_run, tx_pop, rx_push;
    logic              tx_empty, rx_full_w;
    logic [DATA_W-1:0] tx_head, rx_word;
    logic [CNT_W-1:0]  tx_count, rx_count;

    ssm_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n), .push(tx_wr), .din(tx_data),
        .pop(tx_pop), .dout(tx_head), .full(tx_full), .empty(tx_empty),
        .count(tx_count)
    );

    ssm_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word),
        .pop(rx_rd), .dout(rx_data), .full(rx_full_w), .empty(rx_empty),
        .count(rx_count)
    );

    ssm_clkdiv #(.DIV_W(DIV_W)) div_i (
        .clk(clk), .rst_n(rst_n), .run(eng_run), .div(div), .tick(div_tick)
    );

    ssm_engine #(.DATA_W(DATA_W), .CMD_W(CMD_W), .IDX_W(IDX_W)) eng_i (
        .clk(clk), .rst_n(rst_n), .en(en), .fmt(fmt), .wlen(wlen),
        .tick(div_tick), .tx_empty(tx_empty), .tx_word(tx_head), .rxd(rxd),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word), .run(eng_run),
        .sclk(sclk), .sfrm(sfrm), .txd(txd)
    );

    assign tx_req = (tx_count <= HALF);
    assign rx_req = (rx_count >= HALF);
    assign busy   = eng_run || !tx_empty;

    always_ff @(posedge clk) begin
        if (!rst_n || !en)             rx_ovr <= 1'b0;
        else if (rx_push && rx_full_w) rx_ovr <= 1'b1;
    end
endmodule

// File: rtl/ssm_chk.sv
module ssm_chk #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          sclk,
    input logic          busy,
    input logic          rx_ovr,
    input logic          rx_full,
    input logic          tick,
    input logic [CW-1:0] tx_cnt
);
    // R8
    tx_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CW'(DEPTH));

    // R11
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovr && en) |=> rx_ovr);

    // R11
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovr) |-> $past(rx_full));

    // R1
    sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sclk));

    // R10
    busy_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> busy);
endmodule

bind ssm_top ssm_chk #(.DEPTH(FIFO_DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .en(en), .sclk(sclk), .busy(busy),
    .rx_ovr(rx_ovr), .rx_full(rx_full_w), .tick(div_tick), .tx_cnt(tx_count)
);

// File: tb/ssm_top_tb_top.sv
`timescale 1ns/1ps
module ssm_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic [3:0]  wlen = 4'd15;
    logic [7:0]  div = 8'd0;
    logic        tx_wr = 1'b0;
    logic [15:0] tx_data = '0;
    logic        rx_rd = 1'b0;
    logic        tx_full, tx_req, rx_empty, rx_req, rx_ovr, busy;
    logic        sclk, sfrm, txd, rxd;
    logic [15:0] rx_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    // slave model: loopback, or a reply shifter for Microwire
    logic        mw_load = 1'b0;
    logic [23:0] mw_init = '0;
    logic [23:0] mw_stream;
    always @(negedge sclk or posedge mw_load) begin
        if (mw_load) mw_stream <= mw_init;
        else         mw_stream <= {mw_stream[22:0], 1'b0};
    end
    assign rxd = (fmt == 2'd2) ? mw_stream[23] : txd;

    // monitor on rising bit-clock edges
    logic    mon_clr = 1'b0;
    int      rises, frm_hi, period;
    logic [31:0] cap;
    longint  prev_t;
    bit      have_prev;
    always @(posedge sclk or posedge mon_clr) begin
        if (mon_clr) begin
            rises = 0; frm_hi = 0; period = 0; cap = '0; have_prev = 0; prev_t = 0;
        end else begin
            rises++;
            if (sfrm) frm_hi++;
            cap = {cap[30:0], txd};
            if (have_prev) period = int'(($time - prev_t) / 4);
            prev_t = $time;
            have_prev = 1;
        end
    end

    ssm_top dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .fmt(fmt), .wlen(wlen), .div(div),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full), .tx_req(tx_req),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_empty(rx_empty), .rx_req(rx_req),
        .rx_ovr(rx_ovr), .busy(busy), .sclk(sclk), .sfrm(sfrm), .txd(txd),
        .rxd(rxd)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] w);
        @(negedge clk); tx_wr = 1'b1; tx_data = w;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic pop(output logic [15:0] w);
        @(negedge clk); w = rx_data; rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic wait_idle();
        int lim = 0;
        @(negedge clk);
        while (busy && lim < 50000) begin
            @(negedge clk); lim++;
        end
        check(!busy, "R10", "busy never dropped", busy, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic clr_mon();
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
    endtask

    // fmt(2) wlen(4) div(8) tx(16) expected rx(16) expected rises(6)
    localparam logic [51:0] VEC [7] = '{
        {2'd0, 4'd15, 8'd0, 16'hA5C3, 16'hA5C3, 6'd16},
        {2'd0, 4'd7,  8'd2, 16'h12B4, 16'h00B4, 6'd8},
        {2'd0, 4'd3,  8'd1, 16'hFFF9, 16'h0009, 6'd4},
        {2'd1, 4'd15, 8'd0, 16'h8001, 16'h8001, 6'd17},
        {2'd1, 4'd11, 8'd3, 16'hF5A6, 16'h05A6, 6'd13},
        {2'd3, 4'd9,  8'd0, 16'h03FF, 16'h03FF, 6'd10},
        {2'd0, 4'd1,  8'd0, 16'hFFFA, 16'h000A, 6'd4}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        mw_load = 1'b1;
        mon_clr = 1'b1;
        repeat (4) @(negedge clk);
        mw_load = 1'b0;
        mon_clr = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        check(sclk == 0, "R12", "sclk", sclk, 0);
        check(sfrm == 1, "R12", "sfrm idle", sfrm, 1);
        check(txd == 0, "R12", "txd", txd, 0);
        check(busy == 0, "R12", "busy", busy, 0);
        check(rx_empty == 1, "R12", "rx_empty", rx_empty, 1);
        check(tx_req == 1, "R12", "tx_req", tx_req, 1);
        check(rx_req == 0, "R12", "rx_req", rx_req, 0);
        check(rx_ovr == 0, "R12", "rx_ovr", rx_ovr, 0);

        // vector table: loopback frames
        en = 1'b1;
        for (int i = 0; i < 7; i++) begin
            logic [51:0] v;
            int len;
            logic [15:0] mask;
            v = VEC[i];
            @(negedge clk);
            fmt = v[51:50]; wlen = v[49:46]; div = v[45:38];
            len = (v[49:46] < 4'd3) ? 4 : int'(v[49:46]) + 1;
            mask = 16'((32'd1 << len) - 1);
            clr_mon();
            push(v[37:22]);
            wait_idle();
            check(!rx_empty, "R9", "word received", rx_empty, 0);
            pop(w);
            check(w == v[21:6], "R7", "rx word", w, v[21:6]);
            check(rises == int'(v[5:0]), "R2", "bits per frame", rises, v[5:0]);
            check((cap[15:0] & mask) == v[21:6], "R3", "txd MSB first", cap[15:0] & mask, v[21:6]);
            check(frm_hi == ((v[51:50] == 2'd1) ? 1 : 0), (v[51:50] == 2'd1) ? "R5" : "R4",
                  "frame bits high", frm_hi, (v[51:50] == 2'd1) ? 1 : 0);
            check(period == 2 * (int'(v[45:38]) + 1), "R1", "sclk period", period,
                  2 * (int'(v[45:38]) + 1));
        end

        // R6 Microwire: command C6, 10-bit reply 2D3
        @(negedge clk);
        fmt = 2'd2; wlen = 4'd9; div = 8'd1;
        mw_init = {8'h00, 10'h2D3, 6'd0};
        mw_load = 1'b1;
        @(negedge clk); mw_load = 1'b0;
        clr_mon();
        push(16'hAAC6);
        wait_idle();
        pop(w);
        check(w == 16'h02D3, "R6", "microwire reply", w, 16'h02D3);
        check(rises == 18, "R6", "microwire bits", rises, 18);
        check(cap[17:10] == 8'hC6, "R6", "command bits", cap[17:10], 8'hC6);
        check(cap[9:0] == 10'd0, "R6", "txd low in reply", cap[9:0], 0);
        check(frm_hi == 0, "R6", "frame low throughout", frm_hi, 0);

        // FIFO limits with engine disabled
        @(negedge clk);
        en = 1'b0; fmt = 2'd0; wlen = 4'd15; div = 8'd0;
        for (int k = 1; k <= 9; k++) push(16'(k));
        repeat (20) @(negedge clk);
        check(tx_full == 1, "R8", "tx_full", tx_full, 1);
        check(tx_req == 0, "R8", "tx_req when full", tx_req, 0);
        check(busy == 1, "R10", "busy with pending data", busy, 1);
        check(sclk == 0 && rx_empty, "R9", "no frame while disabled", sclk, 0);
        clr_mon();
        en = 1'b1;
        wait_idle();
        check(rises == 128, "R9", "back-to-back bits", rises, 128);
        check(rx_req == 1, "R8", "rx_req", rx_req, 1);
        check(rx_ovr == 0, "R11", "no overrun at exactly full", rx_ovr, 0);
        for (int k = 1; k <= 8; k++) begin
            pop(w);
            check(w == 16'(k), "R8", "fifo order", w, k);
        end
        check(rx_empty == 1, "R8", "ninth write ignored", rx_empty, 1);

        // R11 overrun
        for (int k = 0; k < 8; k++) push(16'h0010 + 16'(k));
        wait_idle();
        push(16'h0099);
        wait_idle();
        check(rx_ovr == 1, "R11", "overrun set", rx_ovr, 1);
        pop(w);
        check(w == 16'h0010, "R11", "overflow word dropped", w, 16'h0010);
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        check(rx_ovr == 0, "R11", "cleared by en low", rx_ovr, 0);
        for (int k = 1; k < 8; k++) begin
            pop(w);
            check(w == 16'h0010 + 16'(k), "R11", "remaining words", w, 16'h0010 + 16'(k));
        end
        check(rx_req == 0 && tx_req == 1, "R8", "requests after drain", rx_req, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule